// File: doc/BRIEF.md
# Performance Counter Control Unit

This block is a compact performance-monitoring unit for one processor core. It holds a 64-bit cycle counter, six 32-bit event counters, an overflow status register and a 32-bit control register. Software reaches all of them through a simple read/write port. A privilege input decides whether an access is allowed. Each event counter has its own strobe input, and a counter adds one on every cycle its strobe is high while counting is enabled.

The control register holds the global enable, self-clearing reset actions for the event counters and the cycle counter, a divide-by-64 mode for the cycle counter, and a selector for the cycle-counter overflow point. The overflow point is either the carry out of bit 31 or the carry out of bit 63. Read-only fields give an identity code and the number of event counters. A counter that wraps past its overflow point sets a sticky status bit, and software clears that bit by writing 1 to it.

Register map (4-bit `reg_addr`):
- 0: control.
- 1: cycle counter bits [31:0].
- 2: cycle counter bits [63:32].
- 3: overflow status.
- 4+i: event counter i, for i from 0 to 5.

Reads are combinational: `reg_rdata` is valid in the same cycle as `reg_rd`, and it is zero when no permitted read is in progress. Writes take effect at the clock edge where `reg_wr` is high. A write to a counter overrides any increment of that counter in the same cycle, and such an increment then reports no overflow.

Top module: `perf_ctl_unit`

## Requirements
- R1: Control register reads return bits [31:24]=0x41, bits [23:16]=0x03, bits [15:11]=6 and bits [10:7]=0, whatever value was last written.
- R2: Control bits E(0), D(3), X(4), DP(5) and LC(6) read back the last value written. Bits P(1) and C(2) always read 0.
- R3: While E=0, neither the cycle counter nor any event counter changes unless software writes to it.
- R4: While E=1 and D=0, the cycle counter adds 1 at every clock edge. While E=1 and D=1, it adds 1 once per 64 enabled edges. Writing C=1 also restarts the divide-by-64 phase.
- R5: A control write with P=1 clears all event counters and leaves the cycle counter alone. A control write with C=1 clears the cycle counter and leaves the event counters alone.
- R6: While E=1, event counter i adds 1 at each edge where evt_strobe[i] is 1.
- R7: An event counter that wraps from 0xFFFFFFFF to 0 sets overflow status bit i (bits 0 to 5).
- R8: With LC=0, a cycle-counter increment that takes bit 31 from 1 to 0 sets overflow status bit 31. With LC=1, only an increment that takes bit 63 from 1 to 0 sets it.
- R9: Overflow status bits stay set until software writes 1 to them at address 3. Writing 0 to a bit has no effect on it. If a bit is set and cleared in the same cycle, it ends up set.
- R10: With priv_lvl=0 and user_en=0, an access is denied. A denied read returns 0, a denied write changes nothing, and access_fault is 1 for the cycle after the denied access. Any priv_lvl other than 0, or user_en=1, allows the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_lvl | input | 2 | Privilege level of the access; 0 is user level |
| user_en | input | 1 | Allows user-level access when 1 |
| reg_rd | input | 1 | Read request |
| reg_wr | input | 1 | Write request |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| evt_strobe | input | 6 | One event pulse per event counter |
| access_fault | output | 1 | One-cycle pulse after a denied access |

## Verification
A corrupted control bit shows up at the next read of address 0. It also shows up as the wrong count after the enable window that the bench sets up. A divide-phase error appears as a cycle count that is off by one step after about 200 enabled edges. A lost or spurious overflow shows in the status register one edge after the increment. A gating error shows as non-zero read data in the same cycle, or as a missing fault pulse one edge later.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned PRIV_W  = 2;
  localparam int unsigned NUM_EVT = 6;
  localparam int unsigned CYC_W   = 64;
  localparam int unsigned PRE_W   = 6;

  localparam logic [7:0] IMPL_CODE = 8'h41;
  localparam logic [7:0] PART_CODE = 8'h03;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_CYC_LO = 4'd1;
  localparam logic [ADDR_W-1:0] A_CYC_HI = 4'd2;
  localparam logic [ADDR_W-1:0] A_OVF    = 4'd3;
  localparam logic [ADDR_W-1:0] A_EVT0   = 4'd4;

  localparam int unsigned B_E  = 0;
  localparam int unsigned B_P  = 1;
  localparam int unsigned B_C  = 2;
  localparam int unsigned B_D  = 3;
  localparam int unsigned B_X  = 4;
  localparam int unsigned B_DP = 5;
  localparam int unsigned B_LC = 6;

  localparam int unsigned CYC_OVF_BIT = 31;

  typedef struct packed {
    logic lc;
    logic dp;
    logic x;
    logic d;
    logic e;
  } ctrl_t;
endpackage

// File: rtl/pcu_prescale.sv
module pcu_prescale #(
  parameter int unsigned W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = clr | run;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (run) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign tick = run & ~clr & (&cnt_q);
endmodule

// File: rtl/pcu_cycle_ctr.sv
module pcu_cycle_ctr #(
  parameter int unsigned W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [W/2-1:0]   wdata,
  input  logic             long_mode,
  output logic [W-1:0]     cnt,
  output logic             ovf
);
  localparam int unsigned H = W / 2;

  logic [W-1:0] cnt_q, cnt_d, inc_val;
  logic         cnt_en, wrap_lo, wrap_hi;

  assign inc_val = cnt_q + W'(1);
  assign cnt_en  = clr | inc | wr_lo | wr_hi;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else begin
      if (inc)   cnt_d = inc_val;
      if (wr_lo) cnt_d[H-1:0] = wdata;
      if (wr_hi) cnt_d[W-1:H] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign wrap_lo = cnt_q[H-1] & ~inc_val[H-1];
  assign wrap_hi = cnt_q[W-1] & ~inc_val[W-1];
  assign ovf     = inc & ~clr & ~wr_lo & ~wr_hi & (long_mode ? wrap_hi : wrap_lo);
  assign cnt     = cnt_q;
endmodule

// File: rtl/pcu_event_ctr.sv
module pcu_event_ctr #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = clr | inc | wr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (wr)  cnt_d = wdata;
    else if (inc) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ovf = inc & ~clr & ~wr & (&cnt_q);
  assign cnt = cnt_q;
endmodule

// File: rtl/pcu_access_gate.sv
module pcu_access_gate #(
  parameter int unsigned PRIV_W = 2
) (
  input  logic [PRIV_W-1:0] priv_lvl,
  input  logic              user_en,
  input  logic              rd_req,
  input  logic              wr_req,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic              deny
);
  logic permit;

  assign permit = (priv_lvl != '0) | user_en;
  assign rd_ok  = rd_req & permit;
  assign wr_ok  = wr_req & permit;
  assign deny   = (rd_req | wr_req) & ~permit;
endmodule

// File: rtl/perf_ctl_unit.sv
module perf_ctl_unit
  import pcu_pkg::*;
#(
  parameter int unsigned NUM_EVT = pcu_pkg::NUM_EVT,
  parameter int unsigned CYC_W   = pcu_pkg::CYC_W,
  parameter int unsigned PRE_W   = pcu_pkg::PRE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRIV_W-1:0] priv_lvl,
  input  logic              user_en,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_EVT-1:0] evt_strobe,
  output logic              access_fault
);
  localparam int unsigned H = CYC_W / 2;

  logic rd_ok, wr_ok, deny;
  logic wr_ctrl, wr_ovf, wr_cyc_lo, wr_cyc_hi;
  logic evt_clr, cyc_clr;
  logic ctrl_e, div_en, div_tick, cyc_inc, cyc_ovf_set;
  logic fault_q;
  ctrl_t ctrl_q, ctrl_d;
  logic [CYC_W-1:0]   cyc_cnt;
  logic [DATA_W-1:0]  evt_cnt [NUM_EVT];
  logic [NUM_EVT-1:0] evt_ovf_set, evt_wr;
  logic [NUM_EVT-1:0] evt_ovf_q, evt_ovf_d;
  logic               cyc_ovf_q, cyc_ovf_d, ovf_en;
  logic [DATA_W-1:0]  ovf_vec, ctrl_word, rd_mux;

  pcu_access_gate #(.PRIV_W(PRIV_W)) u_gate (
    .priv_lvl (priv_lvl),
    .user_en  (user_en),
    .rd_req   (reg_rd),
    .wr_req   (reg_wr),
    .rd_ok    (rd_ok),
    .wr_ok    (wr_ok),
    .deny     (deny)
  );

  assign wr_ctrl   = wr_ok & (reg_addr == A_CTRL);
  assign wr_ovf    = wr_ok & (reg_addr == A_OVF);
  assign wr_cyc_lo = wr_ok & (reg_addr == A_CYC_LO);
  assign wr_cyc_hi = wr_ok & (reg_addr == A_CYC_HI);
  assign evt_clr   = wr_ctrl & reg_wdata[B_P];
  assign cyc_clr   = wr_ctrl & reg_wdata[B_C];

  // control register: next state and storage
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.e  = reg_wdata[B_E];
      ctrl_d.d  = reg_wdata[B_D];
      ctrl_d.x  = reg_wdata[B_X];
      ctrl_d.dp = reg_wdata[B_DP];
      ctrl_d.lc = reg_wdata[B_LC];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  assign ctrl_e = ctrl_q.e;
  assign div_en = ctrl_q.d;

  pcu_prescale #(.W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cyc_clr),
    .run   (ctrl_e & div_en),
    .tick  (div_tick)
  );

  assign cyc_inc = ctrl_e & (div_en ? div_tick : 1'b1);

  pcu_cycle_ctr #(.W(CYC_W)) u_cyc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cyc_clr),
    .inc       (cyc_inc),
    .wr_lo     (wr_cyc_lo),
    .wr_hi     (wr_cyc_hi),
    .wdata     (reg_wdata[H-1:0]),
    .long_mode (ctrl_q.lc),
    .cnt       (cyc_cnt),
    .ovf       (cyc_ovf_set)
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    assign evt_wr[i] = wr_ok & (reg_addr == ADDR_W'(A_EVT0 + i));
    pcu_event_ctr #(.W(DATA_W)) u_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (evt_clr),
      .inc   (ctrl_e & evt_strobe[i]),
      .wr    (evt_wr[i]),
      .wdata (reg_wdata),
      .cnt   (evt_cnt[i]),
      .ovf   (evt_ovf_set[i])
    );
  end

  // overflow status: write-1-to-clear, set takes priority
  always_comb begin
    evt_ovf_d = evt_ovf_q;
    cyc_ovf_d = cyc_ovf_q;
    if (wr_ovf) begin
      evt_ovf_d = evt_ovf_d & ~reg_wdata[NUM_EVT-1:0];
      cyc_ovf_d = cyc_ovf_d & ~reg_wdata[CYC_OVF_BIT];
    end
    evt_ovf_d = evt_ovf_d | evt_ovf_set;
    cyc_ovf_d = cyc_ovf_d | cyc_ovf_set;
  end

  assign ovf_en = wr_ovf | (|evt_ovf_set) | cyc_ovf_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_ovf_q <= '0;
      cyc_ovf_q <= 1'b0;
    end else if (ovf_en) begin
      evt_ovf_q <= evt_ovf_d;
      cyc_ovf_q <= cyc_ovf_d;
    end
  end

  always_comb begin
    ovf_vec = '0;
    ovf_vec[NUM_EVT-1:0] = evt_ovf_q;
    ovf_vec[CYC_OVF_BIT] = cyc_ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= deny;
  end

  assign access_fault = fault_q;

  assign ctrl_word = {IMPL_CODE, PART_CODE, 5'(NUM_EVT), 4'b0000,
                      ctrl_q.lc, ctrl_q.dp, ctrl_q.x, ctrl_q.d, 2'b00, ctrl_q.e};

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL:   rd_mux = ctrl_word;
      A_CYC_LO: rd_mux = cyc_cnt[H-1:0];
      A_CYC_HI: rd_mux = cyc_cnt[CYC_W-1:H];
      A_OVF:    rd_mux = ovf_vec;
      default:  rd_mux = '0;
    endcase
    for (int i = 0; i < NUM_EVT; i++) begin
      if (reg_addr == ADDR_W'(A_EVT0 + i)) rd_mux = evt_cnt[i];
    end
  end

  assign reg_rdata = rd_ok ? rd_mux : '0;
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker
  import pcu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [PRIV_W-1:0] priv_lvl,
  input logic              user_en,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              access_fault,
  input logic              ctrl_e,
  input logic              div_en,
  input logic              wr_ok,
  input logic [CYC_W-1:0]  cyc_cnt,
  input logic [DATA_W-1:0] ovf_vec
);
  logic user_deny;
  assign user_deny = (reg_rd | reg_wr) & (priv_lvl == '0) & ~user_en;

  a_r10_fault_after_deny: assert property (@(posedge clk) disable iff (!rst_n)
    user_deny |=> access_fault);

  a_r10_no_stray_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !user_deny |=> !access_fault);

  a_r10_denied_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && priv_lvl == '0 && !user_en) |-> reg_rdata == '0);

  a_r1_ident_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !user_deny && reg_addr == A_CTRL) |->
      reg_rdata[31:7] == {IMPL_CODE, PART_CODE, 5'd6, 4'd0});

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_e && !wr_ok) |=> $stable(cyc_cnt));

  a_r4_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_e && !div_en && !wr_ok) |=> cyc_cnt == $past(cyc_cnt) + CYC_W'(1));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ok && reg_addr == A_OVF) |=> (ovf_vec & $past(ovf_vec)) == $past(ovf_vec));
endmodule

bind perf_ctl_unit pcu_checker i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_rd       (reg_rd),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .priv_lvl     (priv_lvl),
  .user_en      (user_en),
  .reg_rdata    (reg_rdata),
  .access_fault (access_fault),
  .ctrl_e       (ctrl_e),
  .div_en       (div_en),
  .wr_ok        (wr_ok),
  .cyc_cnt      (cyc_cnt),
  .ovf_vec      (ovf_vec)
);

// File: tb/test_perf_ctl_unit.sv
`timescale 1ns/1ps
module test_perf_ctl_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  priv_lvl;
  logic        user_en;
  logic        reg_rd, reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [5:0]  evt_strobe;
  logic        access_fault;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  logic        fault_seen;

  always #2 clk = ~clk;

  perf_ctl_unit i_perf_ctl_unit (
    .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .user_en(user_en),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_strobe(evt_strobe), .access_fault(access_fault)
  );

  function automatic logic [31:0] exp_ctrl(input logic [31:0] w);
    return {8'h41, 8'h03, 5'd6, 4'd0, w[6], w[5], w[4], w[3], 2'b00, w[0]};
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d, input logic [1:0] pl);
    @(negedge clk);
    priv_lvl = pl; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0; fault_seen = access_fault; priv_lvl = 2'd3;
  endtask

  task automatic rd_reg(input logic [3:0] a, input logic [1:0] pl, output logic [31:0] d);
    @(negedge clk);
    priv_lvl = pl; reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0; fault_seen = access_fault; priv_lvl = 2'd3;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  initial begin
    logic [31:0] rv, w;
    int unsigned exp_evt [6];
    void'($urandom(32'd20240611));
    rst_n = 1'b0; priv_lvl = 2'd3; user_en = 1'b0;
    reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; evt_strobe = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset state
    rd_reg(4'd0, 2'd3, rv); check("R1 reset ctrl", rv, 32'h4103_3000);
    rd_reg(4'd1, 2'd3, rv); check("R3 reset cycle", rv, 0);
    rd_reg(4'd3, 2'd3, rv); check("R9 reset ovf", rv, 0);

    // R1/R2 random control writes
    for (int k = 0; k < 20; k++) begin
      w = $urandom();
      wr_reg(4'd0, w, 2'd3);
      rd_reg(4'd0, 2'd3, rv);
      check("R1/R2 ctrl readback", rv, exp_ctrl(w));
    end
    wr_reg(4'd0, 32'hFFFF_FF86, 2'd3);
    rd_reg(4'd0, 2'd3, rv); check("R2 P and C read 0", rv, exp_ctrl(32'hFFFF_FF86));

    // R3: disabled, strobes active
    wr_reg(4'd0, 32'h6, 2'd3);
    for (int k = 0; k < 10; k++) begin @(negedge clk); evt_strobe = 6'h3F; end
    @(negedge clk); evt_strobe = '0;
    rd_reg(4'd1, 2'd3, rv); check("R3 cycle frozen", rv, 0);
    rd_reg(4'd4, 2'd3, rv); check("R3 event frozen", rv, 0);

    // R4 full rate
    wr_reg(4'd0, 32'h5, 2'd3);
    repeat (49) @(posedge clk);
    wr_reg(4'd0, 32'h0, 2'd3);
    rd_reg(4'd1, 2'd3, rv); check("R4 full rate", rv, 50);
    rd_reg(4'd2, 2'd3, rv); check("R4 high word", rv, 0);
    // R4 divided
    wr_reg(4'd0, 32'hD, 2'd3);
    repeat (199) @(posedge clk);
    wr_reg(4'd0, 32'h0, 2'd3);
    rd_reg(4'd1, 2'd3, rv); check("R4 divide by 64", rv, 3);

    // R5
    wr_reg(4'd6, 32'h0000_1234, 2'd3);
    wr_reg(4'd1, 32'd77, 2'd3);
    wr_reg(4'd0, 32'h2, 2'd3);
    rd_reg(4'd6, 2'd3, rv); check("R5 P clears events", rv, 0);
    rd_reg(4'd1, 2'd3, rv); check("R5 P keeps cycle", rv, 77);
    wr_reg(4'd6, 32'h55, 2'd3);
    wr_reg(4'd0, 32'h4, 2'd3);
    rd_reg(4'd1, 2'd3, rv); check("R5 C clears cycle", rv, 0);
    rd_reg(4'd6, 2'd3, rv); check("R5 C keeps events", rv, 32'h55);

    // R6 random strobes
    wr_reg(4'd0, 32'h3, 2'd3);
    for (int i = 0; i < 6; i++) exp_evt[i] = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      evt_strobe = 6'($urandom());
      for (int i = 0; i < 6; i++) exp_evt[i] += evt_strobe[i];
    end
    @(negedge clk); evt_strobe = '0;
    wr_reg(4'd0, 32'h0, 2'd3);
    for (int i = 0; i < 6; i++) begin
      rd_reg(4'(4 + i), 2'd3, rv);
      check("R6 event count", rv, exp_evt[i]);
    end

    // R7 event wrap
    wr_reg(4'd8, 32'hFFFF_FFFF, 2'd3);
    wr_reg(4'd5, 32'hFFFF_FFFE, 2'd3);
    wr_reg(4'd0, 32'h1, 2'd3);
    @(negedge clk); evt_strobe = 6'b01_0010;
    @(negedge clk); evt_strobe = '0;
    wr_reg(4'd0, 32'h0, 2'd3);
    rd_reg(4'd8, 2'd3, rv); check("R7 wrapped to 0", rv, 0);
    rd_reg(4'd5, 2'd3, rv); check("R7 no wrap", rv, 32'hFFFF_FFFF);
    rd_reg(4'd3, 2'd3, rv); check("R7 ovf bit 4", rv, 32'h10);

    // R9 write-1-to-clear
    wr_reg(4'd3, 32'h1, 2'd3);
    rd_reg(4'd3, 2'd3, rv); check("R9 other bit kept", rv, 32'h10);
    wr_reg(4'd3, 32'h10, 2'd3);
    rd_reg(4'd3, 2'd3, rv); check("R9 cleared", rv, 0);

    // R8 cycle overflow point
    wr_reg(4'd1, 32'hFFFF_FFFE, 2'd3);
    wr_reg(4'd2, 32'h0, 2'd3);
    wr_reg(4'd0, 32'h1, 2'd3);
    repeat (3) @(posedge clk);
    wr_reg(4'd0, 32'h0, 2'd3);
    rd_reg(4'd3, 2'd3, rv); check("R8 LC=0 bit31 wrap", rv, 32'h8000_0000);
    rd_reg(4'd2, 2'd3, rv); check("R8 carry to high", rv, 1);
    wr_reg(4'd3, 32'h8000_0000, 2'd3);
    wr_reg(4'd1, 32'hFFFF_FFFE, 2'd3);
    wr_reg(4'd2, 32'h0, 2'd3);
    wr_reg(4'd0, 32'h41, 2'd3);
    repeat (3) @(posedge clk);
    wr_reg(4'd0, 32'h40, 2'd3);
    rd_reg(4'd3, 2'd3, rv); check("R8 LC=1 no bit31 ovf", rv, 0);
    wr_reg(4'd1, 32'hFFFF_FFFE, 2'd3);
    wr_reg(4'd2, 32'hFFFF_FFFF, 2'd3);
    wr_reg(4'd0, 32'h41, 2'd3);
    repeat (3) @(posedge clk);
    wr_reg(4'd0, 32'h40, 2'd3);
    rd_reg(4'd3, 2'd3, rv); check("R8 LC=1 bit63 wrap", rv, 32'h8000_0000);
    rd_reg(4'd2, 2'd3, rv); check("R8 high wrapped", rv, 0);

    // R10 access gating
    wr_reg(4'd0, 32'h0, 2'd3);
    user_en = 1'b0;
    rd_reg(4'd0, 2'd0, rv); check("R10 denied read zero", rv, 0);
    check("R10 fault after read", fault_seen, 1);
    wr_reg(4'd0, 32'h1, 2'd0); check("R10 fault after write", fault_seen, 1);
    rd_reg(4'd0, 2'd3, rv); check("R10 write ignored", rv, 32'h4103_3000);
    check("R10 no fault when allowed", fault_seen, 0);
    rd_reg(4'd0, 2'd1, rv); check("R10 higher level allowed", rv, 32'h4103_3000);
    user_en = 1'b1;
    wr_reg(4'd0, 32'h10, 2'd0); check("R10 user enabled no fault", fault_seen, 0);
    rd_reg(4'd0, 2'd0, rv); check("R10 user enabled read", rv, 32'h4103_3010);

    summary();
  end
endmodule